// File: doc/BRIEF.md
# Lockable Round-Robin Way Selector

This block chooses the victim way for a set-associative cache of `NUM_SETS` sets and `NUM_WAYS` ways. Each set keeps two numbers: how many of its low ways are locked, and a round-robin pointer. The locked region always starts at way 0 and grows upward by one way at a time. Normal replacement rotates only through the ways above it, so locked lines are never chosen as victims.

An allocate request carries a set index and samples the lock-mode input. With lock mode off, the set's pointer gives the victim and then moves on. With lock mode on, the line goes into the next free way of the locked region, as long as the region has not reached `MAX_LOCK` ways. A separate unlock input frees the locked region of every set at once. The choice is registered. It appears one clock after the request, together with a flag that says whether the new line is locked and a flag that reports a lock request that could not be honoured. Tag storage, hit detection and the data arrays belong to the surrounding cache.

Top module: `lrr_way_select`

## Requirements
- R1: After a synchronous reset, every set's lock count and pointer are 0 and `victim_valid` is low. The first normal allocation to any set then returns way 0.
- R2: `victim_valid` is high in exactly the cycle after a cycle with `alloc_valid` high. `victim_way`, `victim_locked` and `lock_fail` for that request are presented in the same cycle.
- R3: In a set with no locked ways, successive normal allocations return ways 0, 1, ..., `NUM_WAYS-1` and then wrap back to 0.
- R4: A lock-mode allocation (`lock_en`=1) to a set whose lock count c is below `MAX_LOCK` returns way c with `victim_locked`=1 and `lock_fail`=0. It raises that set's count to c+1 and leaves its pointer unchanged.
- R5: A normal allocation to a set with lock count c first raises the pointer to c if it lies below c, then returns the pointer's way. The pointer then advances by one, and from way `NUM_WAYS-1` it returns to c. A victim is therefore never below c.
- R6: A lock-mode allocation to a set whose count already equals `MAX_LOCK` (28) is handled as a normal allocation. It returns `victim_locked`=0 and `lock_fail`=1, and the count stays at `MAX_LOCK`.
- R7: A cycle with `unlock`=1 sets the lock count of every set to 0 and leaves every pointer unchanged.
- R8: If `unlock` and `alloc_valid` are high in the same cycle, the allocation sees a lock count of 0 in its set.
- R9: An allocation changes only the state of the set it addresses.
- R10: Whenever `victim_valid` is low, `victim_locked` and `lock_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request this cycle |
| alloc_set | input | SET_W (5) | Set index of the request |
| lock_en | input | 1 | Lock mode; an allocation made while it is high is locked |
| unlock | input | 1 | Clear the locked region of every set |
| victim_valid | output | 1 | Registered result valid |
| victim_way | output | WAY_W (5) | Chosen way |
| victim_locked | output | 1 | The new line was locked |
| lock_fail | output | 1 | A lock was requested but the set was at its limit |

## Verification
The assertions assume that `alloc_set` is below `NUM_SETS` whenever `alloc_valid` is high, and that `lock_en` and `unlock` are plain levels, sampled only at the clock edge. The stimulus draws set indices only from the valid range. It changes the inputs only on the falling edge. It covers unlocks on their own, unlocks together with allocations, runs of locks that push sets past their limit, and a long mixed stream compared cycle by cycle against a behavioural model of the per-set counts and pointers.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  // Kind of update applied to the addressed set in one cycle
  typedef enum logic [1:0] {
    ALLOC_NONE   = 2'd0,
    ALLOC_NORMAL = 2'd1,
    ALLOC_LOCK   = 2'd2,
    ALLOC_REFUSE = 2'd3
  } alloc_kind_e;
endpackage

// File: rtl/lrr_set_state.sv
module lrr_set_state #(
  parameter int NUM_SETS = 32,
  parameter int MAX_LOCK = 28,
  parameter int SET_W    = 5,
  parameter int WAY_W    = 5,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_locks,
  input  logic [SET_W-1:0] rd_set,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [WAY_W-1:0] rd_ptr,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [WAY_W-1:0] wr_ptr
);
  // The count array is cleared in one cycle, so it lives in flops.
  logic [CNT_W-1:0] cnt_q [NUM_SETS];
  logic [WAY_W-1:0] ptr_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETS; i++) begin
        cnt_q[i] <= '0;
        ptr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SETS; i++) begin
        if (wr_en && (wr_set == SET_W'(i))) begin
          cnt_q[i] <= wr_cnt;
          ptr_q[i] <= wr_ptr;
        end else if (clr_locks) begin
          cnt_q[i] <= '0;
        end
      end
    end
  end

  assign rd_cnt = cnt_q[rd_set];
  assign rd_ptr = ptr_q[rd_set];

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_chk
      // R6: no set ever holds more locked ways than the limit
      a_r6_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g] <= CNT_W'(MAX_LOCK));
      // R7: an unlock without a write to this set leaves its count at 0
      a_r7_unlock_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_locks && !(wr_en && wr_set == SET_W'(g))) |=> (cnt_q[g] == '0));
      // R7, R9: a pointer moves only when its own set is written
      a_r9_ptr_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_set == SET_W'(g)) |=> $stable(ptr_q[g]));
    end
  endgenerate
endmodule

// File: rtl/lrr_pick.sv
module lrr_pick
  import lrr_pkg::*;
#(
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  parameter int WAY_W    = 5,
  parameter int CNT_W    = 5
) (
  input  logic             req,
  input  logic             lock_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [WAY_W-1:0] ptr,
  output alloc_kind_e      kind,
  output logic [WAY_W-1:0] way,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [WAY_W-1:0] nxt_ptr
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_LOCK);

  logic [WAY_W-1:0] floor_w;
  logic [WAY_W-1:0] base;

  assign floor_w = WAY_W'(cnt);
  assign base    = (ptr < floor_w) ? floor_w : ptr;

  always_comb begin
    if (!req)                 kind = ALLOC_NONE;
    else if (!lock_en)        kind = ALLOC_NORMAL;
    else if (cnt < CNT_MAX)   kind = ALLOC_LOCK;
    else                      kind = ALLOC_REFUSE;
  end

  always_comb begin
    way     = base;
    nxt_cnt = cnt;
    nxt_ptr = (base == LAST_WAY) ? floor_w : base + WAY_W'(1);
    if (kind == ALLOC_LOCK) begin
      way     = floor_w;
      nxt_cnt = cnt + CNT_W'(1);
      nxt_ptr = ptr;
    end
  end
endmodule

// File: rtl/lrr_way_select.sv
module lrr_way_select
  import lrr_pkg::*;
#(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int CNT_W   = $clog2(MAX_LOCK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic [SET_W-1:0] alloc_set,
  input  logic             lock_en,
  input  logic             unlock,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_locked,
  output logic             lock_fail
);
  logic [CNT_W-1:0] rd_cnt;
  logic [WAY_W-1:0] rd_ptr;
  logic [CNT_W-1:0] eff_cnt;
  logic [CNT_W-1:0] nxt_cnt;
  logic [WAY_W-1:0] nxt_ptr;
  logic [WAY_W-1:0] pick_way;
  alloc_kind_e      kind;

  lrr_set_state #(
    .NUM_SETS(NUM_SETS), .MAX_LOCK(MAX_LOCK),
    .SET_W(SET_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
  ) u_state (
    .clk(clk), .rst(rst), .clr_locks(unlock),
    .rd_set(alloc_set), .rd_cnt(rd_cnt), .rd_ptr(rd_ptr),
    .wr_en(alloc_valid), .wr_set(alloc_set),
    .wr_cnt(nxt_cnt), .wr_ptr(nxt_ptr)
  );

  // An unlock in the same cycle takes effect before the allocation.
  assign eff_cnt = unlock ? '0 : rd_cnt;

  lrr_pick #(
    .NUM_WAYS(NUM_WAYS), .MAX_LOCK(MAX_LOCK),
    .WAY_W(WAY_W), .CNT_W(CNT_W)
  ) u_pick (
    .req(alloc_valid), .lock_en(lock_en), .cnt(eff_cnt), .ptr(rd_ptr),
    .kind(kind), .way(pick_way), .nxt_cnt(nxt_cnt), .nxt_ptr(nxt_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid  <= 1'b0;
      victim_way    <= '0;
      victim_locked <= 1'b0;
      lock_fail     <= 1'b0;
    end else begin
      victim_valid  <= (kind != ALLOC_NONE);
      victim_locked <= (kind == ALLOC_LOCK);
      lock_fail     <= (kind == ALLOC_REFUSE);
      if (kind != ALLOC_NONE) victim_way <= pick_way;
    end
  end

  // R2: a request yields a result in the next cycle, and only then
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |=> victim_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !alloc_valid |=> !victim_valid);
  // R10: flags are low without a result
  a_r10_flags_idle: assert property (@(posedge clk) disable iff (rst)
    !victim_valid |-> (!victim_locked && !lock_fail));
  // R6: a refused lock never reports a locked line
  a_r6_fail_unlocked: assert property (@(posedge clk) disable iff (rst)
    lock_fail |-> !victim_locked);
  // R4: a locked line always lands inside the lockable range
  a_r4_lock_range: assert property (@(posedge clk) disable iff (rst)
    victim_locked |-> (victim_way < WAY_W'(MAX_LOCK)));
  // R5: a normal victim never falls into the locked region
  a_r5_above_lock: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !lock_en) |=> (victim_way >= WAY_W'($past(eff_cnt))));
  // R8: a lock together with an unlock takes way 0
  a_r8_unlock_alloc: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && lock_en && unlock) |=> (victim_locked && victim_way == '0));
endmodule

// File: tb/sim_lrr_way_select.sv
module sim_lrr_way_select;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int NW = 32;
  localparam int ML = 28;

  logic       clk = 1'b0;
  logic       rst;
  logic       alloc_valid;
  logic [4:0] alloc_set;
  logic       lock_en;
  logic       unlock;
  logic       victim_valid;
  logic [4:0] victim_way;
  logic       victim_locked;
  logic       lock_fail;

  int checks = 0;
  int errors = 0;
  int m_cnt [NS];
  int m_ptr [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  lrr_way_select u0 (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_set(alloc_set),
    .lock_en(lock_en), .unlock(unlock), .victim_valid(victim_valid),
    .victim_way(victim_way), .victim_locked(victim_locked), .lock_fail(lock_fail)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, compare after the rising edge.
  task automatic step(input string tag, input bit av, input int s, input bit le, input bit ul);
    int ew, c, b;
    bit ev, el, ef;
    @(negedge clk);
    alloc_valid = av; alloc_set = 5'(s); lock_en = le; unlock = ul;
    if (ul) for (int i = 0; i < NS; i++) m_cnt[i] = 0;
    ev = av; el = 0; ef = 0; ew = 0;
    if (av) begin
      c = m_cnt[s];
      if (le && c < ML) begin
        ew = c; el = 1; m_cnt[s] = c + 1;
      end else begin
        b = (m_ptr[s] < c) ? c : m_ptr[s];
        ew = b; ef = le;
        m_ptr[s] = (b == NW - 1) ? c : b + 1;
      end
    end
    @(posedge clk);
    #1;
    check(tag, "victim_valid", int'(victim_valid), int'(ev));
    check("R10", "victim_locked", int'(victim_locked), int'(el));
    check("R10", "lock_fail", int'(lock_fail), int'(ef));
    if (ev) check(tag, "victim_way", int'(victim_way), ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; alloc_valid = 0; alloc_set = 0; lock_en = 0; unlock = 0;
    for (int i = 0; i < NS; i++) begin m_cnt[i] = 0; m_ptr[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1", "victim_valid in reset", int'(victim_valid), 0);
    @(negedge clk); rst = 1'b0;
    step("R1", 1, 12, 0, 0);               // first normal alloc: way 0
    step("R2", 0, 0, 0, 0);                // idle: no result
    for (int k = 0; k < 33; k++) step("R3", 1, 3, 0, 0);  // full wrap
    for (int k = 0; k < 8; k++) step("R4", 1, 5, 1, 0);   // lock ways 0..7
    for (int k = 0; k < 30; k++) step("R5", 1, 5, 0, 0);  // rotate 8..31
    for (int k = 0; k < 4; k++) step("R5", 1, 3, 1, 0);   // lock above pointer
    for (int k = 0; k < 5; k++) step("R5", 1, 3, 0, 0);   // pointer lifted
    for (int k = 0; k < 31; k++) step("R6", 1, 7, 1, 0);  // 28 locks, then refusals
    for (int k = 0; k < 6; k++) step("R6", 1, 7, 0, 0);   // rotate over 28..31
    step("R7", 0, 0, 0, 1);                // unlock alone
    for (int k = 0; k < 3; k++) step("R7", 1, 5, 0, 0);   // pointer kept
    step("R7", 1, 7, 1, 0);                // lock restarts at way 0
    step("R8", 1, 7, 1, 1);                // same-cycle unlock: way 0 again
    step("R8", 1, 5, 0, 1);
    for (int k = 0; k < 2500; k++) begin
      automatic int r = $urandom_range(0, 99);
      step("R9", r < 85, $urandom_range(0, 3) * 8 + $urandom_range(0, 1),
           r < 45, r > 97);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule